// File: doc/BRIEF.md
# Secure-Partitioned Backup Register File

This block holds a bank of retained 32-bit general-purpose words that survive software resets and carry state across low-power phases. It is reached over a simple single-cycle register port: a request (read or write, byte address, security attribute, write data) is taken in one cycle and the response (read data plus an error flag) is presented on the following cycle.

A programmable split point divides the bank in two. Words whose index lies below the split are secure and only accept secure requests. Words at or above it serve both kinds of requester. The split point is a register of its own, located just past the data words. Anyone may read it, but only a secure requester may move it. A tamper-detect input wipes every data word in one clock but leaves the split point where it was.

Top module: `secbkp_regfile`

## Requirements
- R1: The bank holds 32 words of 32 bits. Word n sits at byte address 4*n. A secure requester can write and read back every word.
- R2: A word whose index is below the split value is secure. A word whose index is equal to or above the split value is open to both kinds of requester.
- R3: After reset every data word reads zero and the split value is 10.
- R4: A non-secure read of a secure word returns zero data and sets the error flag.
- R5: A non-secure write to a secure word leaves the word unchanged and sets the error flag.
- R6: The split value lives at byte address 0x80 (word 32). Both secure and non-secure requesters can read it without error, and it is returned zero-extended.
- R7: A non-secure write to the split register sets the error flag and leaves the split value unchanged.
- R8: A secure write to the split register of any value above 32 stores 32.
- R9: While tamper_i is high on a clock edge, every data word is cleared at that edge. A data-word read taken in that cycle returns zero.
- R10: A data write in the same cycle as tamper_i is lost: the word reads zero afterwards.
- R11: Tamper erase leaves the split value unchanged.
- R12: An address with nonzero bits [1:0], or a word index above 32, returns zero data, sets the error flag and changes nothing.
- R13: rsp_valid is high exactly one cycle after each request. A write response carries zero data. While rsp_valid is low, rsp_rdata and rsp_err are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Security attribute of the requester (1 = secure) |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| tamper_i | input | 1 | Tamper detected: erase all data words |
| rsp_valid | output | 1 | Response present (one cycle after the request) |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access refused or unmapped |

## Verification
The assertions assume that requests are launched and tamper is raised only on clock edges where reset is released, and that each request lasts exactly one cycle. The port has no back-pressure, so a request that is held high counts as a fresh access on every cycle. The stimulus drives every input on the falling edge, holds it for one cycle and drops req_valid between directed accesses. Tamper pulses are placed both on idle cycles and on cycles that carry a write, a read or a split-register access, so that both sides of each tamper property are covered.

// File: rtl/secbkp_pkg.sv
// Package: shared types and helpers for the secure-partitioned backup register file.
// Assumes nothing beyond being compiled before the modules that import it.
package secbkp_pkg;

    // Class of an address once decoded
    typedef enum logic [1:0] {
        ACC_DATA  = 2'd0,
        ACC_SPLIT = 2'd1,
        ACC_NONE  = 2'd2
    } acc_kind_t;

    // Clamp a requested split value to the number of words
    function automatic int unsigned clamp_split(input logic [31:0] val, input int unsigned limit);
        if (val > 32'(limit)) begin
            return limit;
        end
        return int'(val);
    endfunction

endpackage

// File: rtl/secbkp_decode.sv
// Module: address decode and security filter.
// Purely combinational. It classifies the byte address as a data word, the
// split register or unmapped, and decides whether the request is refused.
// Assumes ADDR_W is wide enough to reach word index NUM_REGS.
module secbkp_decode
    import secbkp_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int ADDR_W   = 8,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int SPL_W   = $clog2(NUM_REGS + 1),
    localparam int WORD_W  = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    input  logic              is_secure,
    input  logic [SPL_W-1:0]  split,
    output acc_kind_t         kind,
    output logic [IDX_W-1:0]  idx,
    output logic              refuse
);

    logic [WORD_W-1:0] word;
    logic              misaligned;
    logic              word_is_secure;

    assign word       = addr[ADDR_W-1:2];
    assign misaligned = (addr[1:0] != 2'b00);

    // Classify the address
    always_comb begin
        if (misaligned || int'(word) > NUM_REGS) begin
            kind = ACC_NONE;
        end else if (int'(word) == NUM_REGS) begin
            kind = ACC_SPLIT;
        end else begin
            kind = ACC_DATA;
        end
    end

    assign idx            = word[IDX_W-1:0];
    assign word_is_secure = (int'(idx) < int'(split));

    // Decide whether the request is refused
    always_comb begin
        unique case (kind)
            ACC_DATA:  refuse = !is_secure && word_is_secure;
            ACC_SPLIT: refuse = is_write && !is_secure;
            default:   refuse = 1'b1;
        endcase
    end

endmodule

// File: rtl/secbkp_bank.sv
// Module: retained storage of NUM_REGS words.
// Each word has its own register. An erase clears all words and takes priority
// over a write in the same cycle. The read port is combinational.
// Assumes that wr_en is raised only for an index below NUM_REGS.
module secbkp_bank #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] words [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        // One retained word: reset or erase clear it, otherwise load on a write hit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (erase) begin
                words[g] <= '0;
            end else if (wr_en && int'(wr_idx) == g) begin
                words[g] <= wr_data;
            end
        end
    end

    // Read mux
    always_comb begin
        rd_data = '0;
        if (int'(rd_idx) < NUM_REGS) begin
            rd_data = words[rd_idx];
        end
    end

endmodule

// File: rtl/secbkp_split.sv
// Module: split-point register.
// It holds the index that separates secure words from open words, loads a
// clamped value on an accepted write, and resets to DEF_SPLIT.
// Assumes the caller has already checked that the writer is secure.
module secbkp_split
    import secbkp_pkg::*;
#(
    parameter int NUM_REGS  = 32,
    parameter int DEF_SPLIT = 10,
    localparam int SPL_W    = $clog2(NUM_REGS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    output logic [SPL_W-1:0] split_q
);

    // Split register: reset default, clamped load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            split_q <= SPL_W'(DEF_SPLIT);
        end else if (wr_en) begin
            split_q <= SPL_W'(clamp_split(wr_data, NUM_REGS));
        end
    end

endmodule

// File: rtl/secbkp_regfile.sv
// Module: top of the secure-partitioned backup register file.
// It takes one request per cycle, filters it against the split point and the
// requester's attribute, and registers the response for the next cycle.
// tamper_i wipes the data words and leaves the split point alone.
// Assumes requests and tamper_i are synchronous to clk.
module secbkp_regfile
    import secbkp_pkg::*;
#(
    parameter int NUM_REGS  = 32,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int DEF_SPLIT = 10,
    localparam int IDX_W    = $clog2(NUM_REGS),
    localparam int SPL_W    = $clog2(NUM_REGS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_secure,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              tamper_i,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);

    acc_kind_t         kind;
    logic [IDX_W-1:0]  idx;
    logic              refuse;
    logic [SPL_W-1:0]  split_q;
    logic [DATA_W-1:0] bank_rd;
    logic              data_we;
    logic              split_we;
    logic [DATA_W-1:0] rd_next;

    secbkp_decode #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) u_decode (
        .addr      (req_addr),
        .is_write  (req_write),
        .is_secure (req_secure),
        .split     (split_q),
        .kind      (kind),
        .idx       (idx),
        .refuse    (refuse)
    );

    assign data_we  = req_valid && req_write && !refuse && (kind == ACC_DATA);
    assign split_we = req_valid && req_write && !refuse && (kind == ACC_SPLIT);

    secbkp_bank #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .erase   (tamper_i),
        .wr_en   (data_we),
        .wr_idx  (idx),
        .wr_data (req_wdata),
        .rd_idx  (idx),
        .rd_data (bank_rd)
    );

    secbkp_split #(
        .NUM_REGS  (NUM_REGS),
        .DEF_SPLIT (DEF_SPLIT)
    ) u_split (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (split_we),
        .wr_data (32'(req_wdata)),
        .split_q (split_q)
    );

    // Select the read data returned for the current request
    always_comb begin
        rd_next = '0;
        if (req_valid && !req_write && !refuse) begin
            if (kind == ACC_SPLIT) begin
                rd_next = DATA_W'(split_q);
            end else if (kind == ACC_DATA && !tamper_i) begin
                rd_next = bank_rd;
            end
        end
    end

    // Response register: one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= rd_next;
            rsp_err   <= req_valid && refuse;
        end
    end

endmodule

// File: rtl/secbkp_checker.sv
// Module: property checker bound to secbkp_regfile.
// It watches the ports and the split point and relates them over time.
// Assumes one request per cycle with inputs stable around the clock edge.
module secbkp_checker #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    localparam int SPL_W   = $clog2(NUM_REGS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_secure,
    input logic [ADDR_W-1:0] req_addr,
    input logic              tamper_i,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_err,
    input logic [SPL_W-1:0]  split_q
);

    logic aligned;
    logic hit_split;
    logic hit_data;

    assign aligned   = (req_addr[1:0] == 2'b00);
    assign hit_split = aligned && int'(req_addr[ADDR_W-1:2]) == NUM_REGS;
    assign hit_data  = aligned && int'(req_addr[ADDR_W-1:2]) < NUM_REGS;

    // R8
    split_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(split_q) <= NUM_REGS);

    // R7
    split_ns_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_secure && hit_split) |=> ($stable(split_q) && rsp_err));

    // R11
    tamper_split_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tamper_i && !(req_valid && req_write)) |=> $stable(split_q));

    // R4
    ns_read_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_secure && hit_data
         && int'(req_addr[ADDR_W-1:2]) < int'(split_q)) |=> (rsp_err && rsp_rdata == '0));

    // R9
    tamper_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tamper_i && req_valid && !req_write && hit_data) |=> (rsp_rdata == '0));

    // R13
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R13
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_err && rsp_rdata == '0));

    // R12
    unmapped_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !aligned) |=> (rsp_err && rsp_rdata == '0));

endmodule

bind secbkp_regfile secbkp_checker #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_secure (req_secure),
    .req_addr   (req_addr),
    .tamper_i   (tamper_i),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .rsp_err    (rsp_err),
    .split_q    (split_q)
);

// File: tb/secbkp_regfile_tb.sv
// Bench: behavioural reference model of the backup register file, compared
// on every clock with the response of the design.
module secbkp_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_secure = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        tamper_i = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;

    int unsigned total = 0;
    int unsigned fails = 0;
    bit          done = 1'b0;

    logic [31:0] m_mem [32];
    int          m_split;

    always #4 clk = ~clk;

    secbkp_regfile u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_secure (req_secure),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .tamper_i   (tamper_i),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .rsp_err    (rsp_err)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) m_mem[i] = '0;
        m_split = 10;
    endtask

    // Reset for a few cycles; entered and left on a falling edge
    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        tamper_i = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        @(posedge clk);
        #1;
        chk("R13 reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R13 reset rsp_err", 32'(rsp_err), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One request cycle: model predicts, design responds one edge later
    task automatic acc(bit wr, bit sec, logic [7:0] addr, logic [31:0] wd, bit tmp, string req);
        int w;
        bit exp_err;
        logic [31:0] exp_rd;
        w = int'(addr >> 2);
        exp_err = 1'b0;
        exp_rd = '0;
        if (addr[1:0] != 2'b00 || w > 32) begin
            exp_err = 1'b1;
        end else if (w == 32) begin
            if (wr) begin
                exp_err = !sec;
                if (sec) m_split = (wd > 32) ? 32 : int'(wd);
            end else begin
                exp_rd = 32'(m_split);
            end
        end else begin
            exp_err = !sec && (w < m_split);
            if (wr) begin
                if (!exp_err && !tmp) m_mem[w] = wd;
            end else if (!exp_err && !tmp) begin
                exp_rd = m_mem[w];
            end
        end
        if (tmp) for (int i = 0; i < 32; i++) m_mem[i] = '0;
        req_valid = 1'b1;
        req_write = wr;
        req_secure = sec;
        req_addr = addr;
        req_wdata = wd;
        tamper_i = tmp;
        @(posedge clk);
        #1;
        chk({req, " valid"}, 32'(rsp_valid), 32'd1);
        chk({req, " err"}, 32'(rsp_err), 32'(exp_err));
        chk({req, " rdata"}, rsp_rdata, exp_rd);
        @(negedge clk);
        req_valid = 1'b0;
        tamper_i = 1'b0;
    endtask

    task automatic idle(bit tmp, string req);
        tamper_i = tmp;
        if (tmp) for (int i = 0; i < 32; i++) m_mem[i] = '0;
        @(posedge clk);
        #1;
        chk({req, " idle valid"}, 32'(rsp_valid), 32'd0);
        chk({req, " idle rdata"}, rsp_rdata, 32'd0);
        @(negedge clk);
        tamper_i = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            fails++;
            total++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        model_reset();
        @(negedge clk);
        do_reset();

        // R3: reset contents and default split
        for (int i = 0; i < 32; i++) acc(0, 1, 8'(4 * i), 0, 0, "R3");
        acc(0, 0, 8'h80, 0, 0, "R3 R6");

        // R1: secure write and read back of every word
        for (int i = 0; i < 32; i++) acc(1, 1, 8'(4 * i), 32'hA5000000 + 32'(i * 7919), 0, "R1");
        for (int i = 0; i < 32; i++) acc(0, 1, 8'(4 * i), 0, 0, "R1");
        idle(0, "R13");

        // R2, R4: edge of the secure group for a non-secure requester
        acc(0, 0, 8'd36, 0, 0, "R4");
        acc(0, 0, 8'd40, 0, 0, "R2");
        acc(1, 0, 8'd40, 32'h1234_5678, 0, "R2");
        acc(0, 0, 8'd40, 0, 0, "R2");

        // R5: refused write leaves the word intact
        acc(1, 0, 8'd20, 32'hDEAD_BEEF, 0, "R5");
        acc(0, 1, 8'd20, 0, 0, "R5");

        // R7: non-secure write to the split register
        acc(1, 0, 8'h80, 32'd3, 0, "R7");
        acc(0, 0, 8'h80, 0, 0, "R7");

        // R2, R6: move the split to 0, then non-secure reaches word 0
        acc(1, 1, 8'h80, 32'd0, 0, "R6");
        acc(0, 0, 8'h80, 0, 0, "R6");
        acc(0, 0, 8'd0, 0, 0, "R2");

        // R8: saturation
        acc(1, 1, 8'h80, 32'd40, 0, "R8");
        acc(0, 1, 8'h80, 0, 0, "R8");
        acc(0, 0, 8'd124, 0, 0, "R8 R4");
        acc(1, 1, 8'h80, 32'hFFFF_FFFF, 0, "R8");
        acc(0, 0, 8'h80, 0, 0, "R8");
        acc(1, 1, 8'h80, 32'd32, 0, "R8");
        acc(0, 0, 8'h80, 0, 0, "R8");

        // R12: misaligned and out-of-range addresses
        acc(0, 1, 8'd2, 0, 0, "R12");
        acc(1, 1, 8'd5, 32'hFFFF_0000, 0, "R12");
        acc(0, 1, 8'd4, 0, 0, "R12");
        acc(0, 1, 8'h84, 0, 0, "R12");
        acc(1, 1, 8'hFC, 32'd1, 0, "R12");
        acc(1, 1, 8'h82, 32'd1, 0, "R12");
        acc(0, 1, 8'h80, 0, 0, "R12");

        // R9, R11: tamper on an idle cycle
        acc(1, 1, 8'h80, 32'd12, 0, "R11");
        idle(1, "R9");
        for (int i = 0; i < 32; i++) acc(0, 1, 8'(4 * i), 0, 0, "R9");
        acc(0, 0, 8'h80, 0, 0, "R11");

        // R10: tamper in the same cycle as a write
        acc(1, 1, 8'd60, 32'h0BAD_F00D, 0, "R10");
        acc(1, 1, 8'd64, 32'hCAFE_0001, 1, "R10");
        acc(0, 1, 8'd64, 0, 0, "R10");
        acc(0, 1, 8'd60, 0, 0, "R10");

        // R9: read during tamper returns zero
        acc(1, 1, 8'd8, 32'h7777_7777, 0, "R9");
        acc(0, 1, 8'd8, 0, 1, "R9");
        acc(0, 1, 8'd8, 0, 0, "R9");

        // R11: split read and write during tamper
        acc(0, 0, 8'h80, 0, 1, "R11");
        acc(1, 1, 8'h80, 32'd5, 1, "R11");
        acc(0, 0, 8'h80, 0, 0, "R11");

        // Mixed traffic across all rules
        for (int n = 0; n < 600; n++) begin
            logic [7:0] a;
            logic [31:0] d;
            int pick;
            pick = int'($urandom_range(0, 99));
            if (pick < 8) a = 8'h80;
            else if (pick < 12) a = 8'($urandom_range(0, 255));
            else a = 8'(4 * $urandom_range(0, 31));
            d = (a == 8'h80) ? 32'($urandom_range(0, 40)) : $urandom;
            acc($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, a, d,
                $urandom_range(0, 39) == 0, "R1 R2 R4 R5 mix");
            if (pick > 95) idle(0, "R13");
        end

        // R3: reset in the middle of traffic restores the defaults
        do_reset();
        acc(0, 0, 8'h80, 0, 0, "R3");
        acc(0, 1, 8'd124, 0, 0, "R3");
        acc(0, 0, 8'd36, 0, 0, "R3");

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule